// File: doc/BRIEF.md
# Infrared Pulse-Train Capture Engine

This block records the output of a demodulated infrared receiver as a list of level durations. It writes the list into a local capture buffer that the host reads through a separate address port. The host pulses an arm command to start. The engine then waits for light to appear on the receiver line. From that point it measures how long each light and dark level lasts, and it writes one entry per level change. A capture ends in one of three ways: the line stays quiet for a programmable number of ticks, the buffer fills, or no light arrives at all within a long arm window.

The receiver line passes through a polarity option, a two-stage synchronizer and a glitch filter before any timing is taken. Durations are counted in ticks of a free-running prescaler. The host reads three results: a completion flag that it can poll, the recorded length in bytes, and an overflow flag. These results stay frozen until the next arm command.

Top module: `ir_capture_top`

## Requirements
- R1: While reset is held and directly after it, done_o, ovf_o and len_o are all zero.
- R2: On the clock after arm_i is sampled high, done_o and ovf_o are 0 and len_o is 0, whatever state the engine was in. The engine then waits for light.
- R3: While armed and waiting, no entry is stored until the filtered receiver level first shows light. The first stored entry is always a light duration.
- R4: With invert_i=0 a low receiver line means light. With invert_i=1 a high line means light.
- R5: Each filtered level change stores one DUR_W-bit entry at the next address, starting at address 0. The entry holds the number of prescaler ticks (one per PRESCALE clocks) that the previous level lasted. Entries alternate light, dark, light and so on.
- R6: Once IDLE_TICKS ticks pass with no level change during recording, done_o rises. The duration of that trailing level is not stored.
- R7: len_o always equals twice the number of stored entries, and it never exceeds 2*DEPTH.
- R8: When the DEPTH-th entry is written, capture stops and done_o and ovf_o both rise. ovf_o is never 1 while done_o is 0.
- R9: If no light arrives within ARM_TICKS ticks of arming, done_o rises with len_o=0 and ovf_o=0.
- R10: A synchronized level that lasts fewer than FILT_LEN clocks is ignored. It neither starts a capture nor stores an entry.
- R11: After done_o rises, done_o, ovf_o and len_o hold their values until the next arm_i, whatever happens on ir_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | One-cycle command to start a new capture |
| invert_i | input | 1 | Receiver polarity: 0 means low is light, 1 means high is light |
| ir_i | input | 1 | Raw receiver line (asynchronous) |
| rd_addr_i | input | $clog2(DEPTH) | Capture buffer read address |
| rd_data_o | output | DUR_W | Stored duration at rd_addr_i (combinational read) |
| len_o | output | $clog2(DEPTH+1)+1 | Recorded length in bytes |
| done_o | output | 1 | Capture finished |
| ovf_o | output | 1 | Capture stopped because the buffer filled |

## Verification
A change on ir_i reaches the control logic after 2+FILT_LEN clock edges: two synchronizer stages, then FILT_LEN edges of filtering. The engine updates done_o, len_o and ovf_o on the edge that sees the filtered change or the expiring tick count, and the ports show the new values from that edge onward. arm_i clears the results one edge after it is sampled. The bench drives every input at the falling edge. Its behavioural model steps at each rising edge using the input values already driven. All three outputs are compared with the model at the next falling edge, so each result is checked exactly in the cycle it is due. Buffer contents are read through the combinational port shortly after a falling edge and compared both with the model and with durations derived from the driven pulse widths.

// File: rtl/ir_capture_pkg.sv
package ir_capture_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_REC  = 2'd2
  } cap_state_e;
endpackage

// File: rtl/ir_sync_filter.sv
module ir_sync_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ir_i,
  input  logic invert_i,
  output logic on_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic             sync_q1, sync_q2;
  logic [CNT_W-1:0] run_q;
  logic             on_q;

  // polarity applied before synchronizing so the filter sees light-on directly
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
    end else begin
      sync_q1 <= invert_i ? ir_i : ~ir_i;
      sync_q2 <= sync_q1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      on_q  <= 1'b0;
    end else if (sync_q2 == on_q) begin
      run_q <= '0;
    end else if (run_q == CNT_W'(FILT_LEN - 1)) begin
      run_q <= '0;
      on_q  <= sync_q2;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign on_o = on_q;
endmodule

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int PRESCALE = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [CNT_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              div_q <= '0;
    else if (div_q == CNT_W'(PRESCALE - 1))   div_q <= '0;
    else                                      div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == CNT_W'(PRESCALE - 1));
endmodule

// File: rtl/ir_rx_buffer.sv
module ir_rx_buffer #(
  parameter int DUR_W = 16,
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DUR_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DUR_W-1:0]  rdata_o
);
  logic [DUR_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ir_capture_ctrl.sv
module ir_capture_ctrl
  import ir_capture_pkg::*;
#(
  parameter int DUR_W      = 16,
  parameter int DEPTH      = 64,
  parameter int IDLE_TICKS = 2000,
  parameter int ARM_TICKS  = 50000,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = $clog2(DEPTH + 1),
  localparam int ARM_W  = (ARM_TICKS > 1) ? $clog2(ARM_TICKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              tick_i,
  input  logic              on_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DUR_W-1:0]  wdata_o,
  output logic [PTR_W-1:0]  count_o,
  output logic              done_o,
  output logic              ovf_o
);
  cap_state_e       st_q;
  logic [PTR_W-1:0] ptr_q;
  logic [DUR_W-1:0] dur_q;
  logic [ARM_W-1:0] arm_cnt_q;
  logic             lvl_q, done_q, ovf_q;
  logic             edge_seen;

  assign edge_seen = (st_q == ST_REC) && (on_i != lvl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ptr_q     <= '0;
      dur_q     <= '0;
      arm_cnt_q <= '0;
      lvl_q     <= 1'b0;
      done_q    <= 1'b0;
      ovf_q     <= 1'b0;
    end else if (arm_i) begin
      st_q      <= ST_WAIT;
      ptr_q     <= '0;
      dur_q     <= '0;
      arm_cnt_q <= '0;
      lvl_q     <= 1'b0;
      done_q    <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      case (st_q)
        ST_WAIT: begin
          if (on_i) begin
            st_q  <= ST_REC;
            dur_q <= '0;
            lvl_q <= 1'b1;
          end else if (tick_i) begin
            if (arm_cnt_q == ARM_W'(ARM_TICKS - 1)) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              arm_cnt_q <= arm_cnt_q + 1'b1;
            end
          end
        end
        ST_REC: begin
          if (edge_seen) begin
            ptr_q <= ptr_q + 1'b1;
            dur_q <= '0;
            lvl_q <= on_i;
            if (ptr_q == PTR_W'(DEPTH - 1)) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              ovf_q  <= 1'b1;
            end
          end else if (tick_i) begin
            // trailing level is dropped on timeout
            if (dur_q == DUR_W'(IDLE_TICKS - 1)) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              dur_q <= dur_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign we_o    = edge_seen && !arm_i;
  assign waddr_o = ptr_q[ADDR_W-1:0];
  assign wdata_o = dur_q;
  assign count_o = ptr_q;
  assign done_o  = done_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/ir_capture_top.sv
module ir_capture_top #(
  parameter int DUR_W      = 16,
  parameter int DEPTH      = 64,
  parameter int PRESCALE   = 100,
  parameter int FILT_LEN   = 3,
  parameter int IDLE_TICKS = 2000,
  parameter int ARM_TICKS  = 50000,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = $clog2(DEPTH + 1),
  localparam int LEN_W  = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              invert_i,
  input  logic              ir_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DUR_W-1:0]  rd_data_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              done_o,
  output logic              ovf_o
);
  logic              on_filt, tick;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DUR_W-1:0]  wr_data;
  logic [PTR_W-1:0]  entry_cnt;

  ir_sync_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ir_i     (ir_i),
    .invert_i (invert_i),
    .on_o     (on_filt)
  );

  ir_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  ir_capture_ctrl #(
    .DUR_W      (DUR_W),
    .DEPTH      (DEPTH),
    .IDLE_TICKS (IDLE_TICKS),
    .ARM_TICKS  (ARM_TICKS)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm_i),
    .tick_i  (tick),
    .on_i    (on_filt),
    .we_o    (wr_en),
    .waddr_o (wr_addr),
    .wdata_o (wr_data),
    .count_o (entry_cnt),
    .done_o  (done_o),
    .ovf_o   (ovf_o)
  );

  ir_rx_buffer #(.DUR_W(DUR_W), .DEPTH(DEPTH)) u_buf (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (wr_data),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  // one entry = one DUR_W=16-bit word = two bytes
  assign len_o = {entry_cnt, 1'b0};
endmodule

// File: rtl/ir_capture_chk.sv
module ir_capture_chk #(
  parameter int DEPTH = 64,
  localparam int LEN_W = $clog2(DEPTH + 1) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arm_i,
  input logic [LEN_W-1:0] len_o,
  input logic             done_o,
  input logic             ovf_o
);
  AST_ARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (!done_o && !ovf_o && len_o == '0)); // R2

  AST_LEN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (len_o == $past(len_o) || 32'(len_o) == 32'($past(len_o)) + 2)); // R5

  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(len_o) <= 2 * DEPTH); // R7

  AST_OVF_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> done_o); // R8

  AST_DONE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i) |=> (done_o && $stable(len_o) && $stable(ovf_o))); // R11
endmodule

bind ir_capture_top ir_capture_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .arm_i  (arm_i),
  .len_o  (len_o),
  .done_o (done_o),
  .ovf_o  (ovf_o)
);

// File: tb/ir_capture_top_test.sv
`timescale 1ns/1ps
module ir_capture_top_test;
  localparam int DUR_W = 16, DEPTH = 8, PRESCALE = 4, FILT_LEN = 3;
  localparam int IDLE_TICKS = 20, ARM_TICKS = 50;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int LEN_W = $clog2(DEPTH + 1) + 1;

  logic              clk_i = 1'b0, rst_ni = 1'b0, arm_i = 1'b0, invert_i = 1'b0, ir_i = 1'b1;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [DUR_W-1:0]  rd_data_o;
  logic [LEN_W-1:0]  len_o;
  logic              done_o, ovf_o;

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ir_capture_top #(
    .DUR_W(DUR_W), .DEPTH(DEPTH), .PRESCALE(PRESCALE), .FILT_LEN(FILT_LEN),
    .IDLE_TICKS(IDLE_TICKS), .ARM_TICKS(ARM_TICKS)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .invert_i(invert_i), .ir_i(ir_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .len_o(len_o), .done_o(done_o), .ovf_o(ovf_o)
  );

  // behavioural reference: history of light samples, then a phase machine
  int  hist[$];
  int  m_pc, m_phase, m_n, m_dur, m_acnt, m_lvl, m_filt;
  bit  m_done, m_ovf;
  int  m_mem[DEPTH];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = {};
      for (int i = 0; i < FILT_LEN + 2; i++) hist.push_front(0);
      m_pc = 0; m_phase = 0; m_n = 0; m_dur = 0; m_acnt = 0; m_lvl = 0; m_filt = 0;
      m_done = 0; m_ovf = 0;
    end else begin
      int  f_old, tk, flip;
      f_old = m_filt;
      tk = (m_pc == PRESCALE - 1);
      flip = 1;
      for (int k = 1; k <= FILT_LEN; k++) if (hist[k] == m_filt) flip = 0;
      if (flip) m_filt = 1 - m_filt;
      hist.push_front(invert_i ? int'(ir_i) : int'(!ir_i));
      void'(hist.pop_back());
      m_pc = tk ? 0 : m_pc + 1;
      if (arm_i) begin
        m_phase = 1; m_done = 0; m_ovf = 0; m_n = 0; m_dur = 0; m_acnt = 0;
      end else if (m_phase == 1) begin
        if (f_old == 1) begin m_phase = 2; m_dur = 0; m_lvl = 1; end
        else if (tk) begin
          if (m_acnt == ARM_TICKS - 1) begin m_phase = 0; m_done = 1; end
          else m_acnt++;
        end
      end else if (m_phase == 2) begin
        if (f_old != m_lvl) begin
          m_mem[m_n] = m_dur; m_n++; m_dur = 0; m_lvl = f_old;
          if (m_n == DEPTH) begin m_phase = 0; m_done = 1; m_ovf = 1; end
        end else if (tk) begin
          if (m_dur == IDLE_TICKS - 1) begin m_phase = 0; m_done = 1; end
          else m_dur++;
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      check("R6 done_o", int'(done_o), int'(m_done));
      check("R7 len_o", int'(len_o), 2 * m_n);
      check("R8 ovf_o", int'(ovf_o), int'(m_ovf));
    end
  end

  task automatic drive(int light, int cyc);
    ir_i = invert_i ? light[0] : !light[0];
    repeat (cyc) @(negedge clk_i);
  endtask

  task automatic arm();
    arm_i = 1'b1;
    @(negedge clk_i);
    arm_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic wait_done(int max);
    for (int i = 0; i < max && !done_o; i++) @(negedge clk_i);
  endtask

  task automatic check_mem(string req);
    for (int a = 0; a < m_n; a++) begin
      rd_addr_i = ADDR_W'(a);
      #1;
      check(req, int'(rd_data_o), m_mem[a]);
    end
    @(negedge clk_i);
  endtask

  task automatic near(string req, int a, int ticks);
    rd_addr_i = ADDR_W'(a);
    #1;
    checks++;
    if (int'(rd_data_o) < ticks - 1 || int'(rd_data_o) > ticks + 1) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d+-1", req, rd_data_o, ticks);
    end
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 done_o", int'(done_o), 0);
    check("R1 ovf_o", int'(ovf_o), 0);
    check("R1 len_o", int'(len_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 len_o after reset", int'(len_o), 0);

    // normal polarity capture
    arm();
    check("R2 done cleared", int'(done_o), 0);
    drive(0, 30);
    check("R3 nothing before light", int'(len_o), 0);
    drive(1, 40); drive(0, 24); drive(1, 16); drive(0, 60); drive(1, 12);
    drive(0, 10);
    wait_done(200);
    check("R6 done after idle", int'(done_o), 1);
    check("R7 five entries", int'(len_o), 10);
    near("R5 light entry 0", 0, 10);
    near("R5 dark entry 1", 1, 6);
    near("R5 light entry 2", 2, 4);
    check_mem("R5 buffer");
    drive(1, 20); drive(0, 20);
    check("R11 len frozen", int'(len_o), 10);

    // inverted polarity
    invert_i = 1'b1;
    drive(0, 10);
    arm();
    drive(0, 20);
    check("R4 inverted idle low", int'(len_o), 0);
    drive(1, 20); drive(0, 20); drive(1, 28); drive(0, 8);
    wait_done(200);
    check("R4 inverted entries", int'(len_o), 6);
    near("R4 inverted entry 2", 2, 7);
    check_mem("R4 buffer");
    invert_i = 1'b0;
    drive(0, 10);

    // arm timeout
    arm();
    wait_done(400);
    check("R9 done", int'(done_o), 1);
    check("R9 len", int'(len_o), 0);
    check("R9 ovf", int'(ovf_o), 0);

    // glitches ignored
    arm();
    drive(1, 1); drive(0, 10); drive(1, 2); drive(0, 10);
    check("R10 glitch no start", int'(len_o), 0);
    check("R10 glitch not done", int'(done_o), 0);
    drive(1, 24); drive(0, 1); drive(1, 20); drive(0, 10);
    wait_done(200);
    check("R10 one entry", int'(len_o), 2);
    near("R10 merged light", 0, 11);

    // overflow
    arm();
    for (int p = 0; p < 5; p++) begin drive(1, 12); drive(0, 12); end
    drive(0, 20);
    check("R8 ovf", int'(ovf_o), 1);
    check("R8 done", int'(done_o), 1);
    check("R8 len full", int'(len_o), 2 * DEPTH);
    check_mem("R8 buffer");

    // re-arm during recording
    arm();
    drive(1, 16); drive(0, 16); drive(1, 8);
    arm();
    check("R2 rearm clears len", int'(len_o), 0);
    drive(0, 10);
    wait_done(200);
    check("R2 rearm capture", int'(len_o), 2);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule